// File: doc/BRIEF.md
# Power-Management Event Register Block

This block is a small power-management register file mapped into I/O space. It holds a 16-bit event status register, a 16-bit event enable register, a 16-bit control register and a free-running timer that can be read. The register file occupies a 64-byte I/O window. The window base comes from a configuration word, and decoding is switched on or off by a configuration bit. Software reads and writes the registers through a request/response port. Hardware event pulses (power button, real-time clock alarm, global lock) and the timer's most-significant-bit change set status bits. Status bits are cleared by writing one to them.

The block drives a level-sensitive system control interrupt (`sci_o`). It is high whenever an enabled event status bit is set or the external general-purpose event request is high. A separate command byte input turns the SCI-enable bit of the control register on or off. When a configuration bit allows it, each command byte also produces a one-cycle system-management interrupt pulse. A 32-bit miscellaneous configuration word is kept locally. Reset clears it, and a strap input can preset its SMI-allow bit during reset.

I/O requests use valid/ready. `io_req_ready` is low while a read response is waiting. A read response rises the cycle after the read is accepted. It holds its data until `io_rsp_ready` is seen high at a clock edge. Writes are accepted in one cycle and produce no response.

Top module: `pmev_regblock`

## Requirements
- R1: An access hits only when `cfg_io_decode` is 1 and address bits [15:6] equal bits [15:6] of `cfg_io_base` (the base is `cfg_io_base` AND 0xFFC0). A read that misses returns `io_rsp_hit`=0 with data 0, and a write that misses changes no register.
- R2: Window offsets: 0x00 event status, 0x02 event enable, 0x04 control, 0x08 timer (a word read returns the timer zero-extended to 32 bits). Any other offset reads 0, and writes to it or to the timer are ignored.
- R3: With `io_req_byte`=1, address bit 0 selects the low (0) or high (1) byte of the addressed 16-bit register. A read returns that byte in data[7:0] with the upper bits 0. A write uses `io_req_wdata[7:0]` and changes only that byte.
- R4: Status bit 0 is timer, bit 5 is global lock, bit 8 is power button and bit 10 is real-time clock. An event input pulse sets its bit. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An event in the same cycle as a clear wins. All other status bits read 0.
- R5: `sci_o` is high exactly when (status AND enable) has any of bits 0, 5, 8 or 10 set, or when `gpe_req` is high. It reflects a status or enable write from the clock edge that accepts the write.
- R6: The timer is a TMR_W-bit up-counter (default 24) that is 0 after reset and adds 1 every cycle. Status bit 0 sets at the clock edge after the edge at which the counter's most significant bit changes.
- R7: `tmr_armed` is high exactly when enable bit 0 is set and status bit 0 is clear.
- R8: A command byte 0xF1 sets control bit 0 (SCI enable), and 0xF0 clears it, at the edge that accepts the command. Other command values leave the control register unchanged. A command takes precedence over an I/O write to control bit 0 in the same cycle.
- R9: After any accepted command byte, `smi_o` is high for exactly the next cycle if bit 25 of the miscellaneous configuration word (bit 1 of its top byte) is set. Otherwise it stays low.
- R10: Reset clears status, enable, control and the timer. It sets the miscellaneous word to 0x02000000 when `smi_strap` is 1 and to 0 otherwise. `cfg_misc_we` loads all 32 bits of `cfg_misc_wdata`.
- R11: `io_req_ready` is low while a response is pending. A read response appears the cycle after acceptance and keeps its valid, hit and data unchanged until consumed with `io_rsp_ready`. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_io_base | input | 32 | Window base configuration word (masked to 64-byte alignment) |
| cfg_io_decode | input | 1 | Window decode enable |
| cfg_misc_we | input | 1 | Load strobe for the miscellaneous configuration word |
| cfg_misc_wdata | input | 32 | New miscellaneous configuration word |
| cfg_misc_q | output | 32 | Current miscellaneous configuration word |
| smi_strap | input | 1 | Presets SMI-allow bit 25 during reset |
| io_req_valid | input | 1 | I/O request valid |
| io_req_ready | output | 1 | I/O request ready |
| io_req_write | input | 1 | 1 = write, 0 = read |
| io_req_byte | input | 1 | 1 = byte access, 0 = word access |
| io_req_addr | input | 16 | I/O address |
| io_req_wdata | input | 16 | Write data |
| io_rsp_valid | output | 1 | Read response valid |
| io_rsp_ready | input | 1 | Read response accepted |
| io_rsp_hit | output | 1 | Read fell inside the decoded window |
| io_rsp_data | output | 32 | Read data |
| evt_pwrbtn | input | 1 | Power-button event pulse |
| evt_rtc | input | 1 | Real-time-clock alarm pulse |
| evt_glbl | input | 1 | Global-lock release pulse |
| gpe_req | input | 1 | External general-purpose event request level |
| apm_cmd_valid | input | 1 | Command byte strobe |
| apm_cmd_data | input | 8 | Command byte |
| sci_o | output | 1 | System control interrupt level |
| smi_o | output | 1 | System-management interrupt pulse |
| tmr_armed | output | 1 | Timer overflow interrupt armed |

## Verification
Assertions check the response-holding rule under back-pressure, the zero data of a miss, and the effect of the 0xF1/0xF0 commands on the SCI-enable bit on every cycle. They also check that an SMI pulse always follows a command, that a timer tick always sets the timer status bit, that a clear without a coincident event always drops its status bits, and that the timer steps by one. Only the directed scenarios can show other behaviour: the address decode under a relocated or disabled window, byte-lane steering, masking of the SCI sources, the SCI level following writes, the strap reset value, and timer read values.

// File: rtl/pmev_pkg.sv
package pmev_pkg;

  localparam int REG_W = 16;

  localparam int STS_TMR    = 0;
  localparam int STS_GLBL   = 5;
  localparam int STS_PWRBTN = 8;
  localparam int STS_RTC    = 10;

  localparam logic [REG_W-1:0] STS_IMPL =
    (REG_W'(1) << STS_TMR) | (REG_W'(1) << STS_GLBL) |
    (REG_W'(1) << STS_PWRBTN) | (REG_W'(1) << STS_RTC);

  localparam logic [REG_W-1:0] SCI_SRC_MASK = STS_IMPL;

  localparam logic [7:0] CMD_SCI_ON  = 8'hF1;
  localparam logic [7:0] CMD_SCI_OFF = 8'hF0;

  localparam int MISC_SMI_BIT = 25;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STS,
    SEL_EN,
    SEL_CTL,
    SEL_TMR
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
    logic     hi_byte;
  } dec_t;

endpackage

// File: rtl/pmev_decode.sv
module pmev_decode
  import pmev_pkg::*;
#(
  parameter int IO_AW    = 16,
  parameter int WIN_BITS = 6
) (
  input  logic [IO_AW-1:0] addr,
  input  logic [31:0]      base_word,
  input  logic             decode_en,
  output dec_t             dec
);

  localparam int IDX_W = WIN_BITS - 1;
  localparam logic [31:0] BASE_MASK =
    32'((64'd1 << IO_AW) - 64'd1) & ~32'((64'd1 << WIN_BITS) - 64'd1);

  logic [31:0]      base_masked;
  logic [31:0]      addr_ext;
  logic [IDX_W-1:0] idx;

  assign base_masked = base_word & BASE_MASK;
  assign addr_ext    = 32'(addr);
  assign idx         = addr[WIN_BITS-1:1];

  always_comb begin
    dec.hit     = decode_en && (addr_ext[31:WIN_BITS] == base_masked[31:WIN_BITS]);
    dec.hi_byte = addr[0];
    case (idx)
      IDX_W'(0): dec.sel = SEL_STS;
      IDX_W'(1): dec.sel = SEL_EN;
      IDX_W'(2): dec.sel = SEL_CTL;
      IDX_W'(4): dec.sel = SEL_TMR;
      default:   dec.sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/pmev_timer.sv
module pmev_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [TMR_W-1:0] count,
  output logic             tick
);

  logic msb_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      msb_prev <= 1'b0;
    end else begin
      count    <= count + TMR_W'(1);
      msb_prev <= count[TMR_W-1];
    end
  end

  assign tick = count[TMR_W-1] ^ msb_prev;

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count == $past(count) + TMR_W'(1)); // R6

endmodule

// File: rtl/pmev_evt_regs.sv
module pmev_evt_regs
  import pmev_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] evt_set,
  input  logic             tmr_tick,
  input  logic [REG_W-1:0] wdata,
  input  logic [1:0]       wbe,
  input  logic             wr_sts,
  input  logic             wr_en,
  input  logic             wr_ctl,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_data,
  input  logic             misc_we,
  input  logic [31:0]      misc_wdata,
  input  logic             strap,
  input  logic             gpe_req,
  output logic [REG_W-1:0] sts_q,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] ctl_q,
  output logic [31:0]      misc_q,
  output logic             sci,
  output logic             armed,
  output logic             smi
);

  logic [REG_W-1:0] lane_mask;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] ctl_d;

  assign lane_mask = {{(REG_W/2){wbe[1]}}, {(REG_W/2){wbe[0]}}};
  assign set_vec   = (evt_set | (REG_W'(tmr_tick) << STS_TMR)) & STS_IMPL;
  assign clr_vec   = wr_sts ? (wdata & lane_mask) : '0;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) ctl_d = (ctl_q & ~lane_mask) | (wdata & lane_mask);
    if (cmd_valid && cmd_data == CMD_SCI_ON)  ctl_d[0] = 1'b1;
    if (cmd_valid && cmd_data == CMD_SCI_OFF) ctl_d[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q  <= '0;
      en_q   <= '0;
      ctl_q  <= '0;
      smi    <= 1'b0;
      misc_q <= strap ? (32'd1 << MISC_SMI_BIT) : 32'd0;
    end else begin
      sts_q <= ((sts_q & ~clr_vec) | set_vec) & STS_IMPL;
      if (wr_en) en_q <= (en_q & ~lane_mask) | (wdata & lane_mask);
      ctl_q <= ctl_d;
      smi   <= cmd_valid & misc_q[MISC_SMI_BIT];
      if (misc_we) misc_q <= misc_wdata;
    end
  end

  assign sci   = (|(sts_q & en_q & SCI_SRC_MASK)) | gpe_req;
  assign armed = en_q[STS_TMR] & ~sts_q[STS_TMR];

  AST_CMD_SCI_ON: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_data == CMD_SCI_ON |=> ctl_q[0]); // R8

  AST_CMD_SCI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_data == CMD_SCI_OFF |=> !ctl_q[0]); // R8

  AST_TICK_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tick |=> sts_q[STS_TMR]); // R6

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec & STS_IMPL) != '0) |=>
      ((sts_q & $past(clr_vec & ~set_vec & STS_IMPL)) == '0)); // R4

endmodule

// File: rtl/pmev_regblock.sv
module pmev_regblock
  import pmev_pkg::*;
#(
  parameter int IO_AW    = 16,
  parameter int WIN_BITS = 6,
  parameter int TMR_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_io_base,
  input  logic             cfg_io_decode,
  input  logic             cfg_misc_we,
  input  logic [31:0]      cfg_misc_wdata,
  output logic [31:0]      cfg_misc_q,
  input  logic             smi_strap,
  input  logic             io_req_valid,
  output logic             io_req_ready,
  input  logic             io_req_write,
  input  logic             io_req_byte,
  input  logic [IO_AW-1:0] io_req_addr,
  input  logic [REG_W-1:0] io_req_wdata,
  output logic             io_rsp_valid,
  input  logic             io_rsp_ready,
  output logic             io_rsp_hit,
  output logic [31:0]      io_rsp_data,
  input  logic             evt_pwrbtn,
  input  logic             evt_rtc,
  input  logic             evt_glbl,
  input  logic             gpe_req,
  input  logic             apm_cmd_valid,
  input  logic [7:0]       apm_cmd_data,
  output logic             sci_o,
  output logic             smi_o,
  output logic             tmr_armed
);

  dec_t             dec;
  logic [TMR_W-1:0] tmr_count;
  logic             tmr_tick;
  logic [REG_W-1:0] sts_q, en_q, ctl_q;
  logic [REG_W-1:0] evt_vec;
  logic [REG_W-1:0] wdata16;
  logic [1:0]       wbe;
  logic             accept, wr_fire;
  logic [31:0]      tmr32;
  logic [REG_W-1:0] sel_val;
  logic [31:0]      rd_data;

  pmev_decode #(.IO_AW(IO_AW), .WIN_BITS(WIN_BITS)) u_decode (
    .addr      (io_req_addr),
    .base_word (cfg_io_base),
    .decode_en (cfg_io_decode),
    .dec       (dec)
  );

  pmev_timer #(.TMR_W(TMR_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .count (tmr_count),
    .tick  (tmr_tick)
  );

  always_comb begin
    evt_vec             = '0;
    evt_vec[STS_PWRBTN] = evt_pwrbtn;
    evt_vec[STS_RTC]    = evt_rtc;
    evt_vec[STS_GLBL]   = evt_glbl;
  end

  assign io_req_ready = !io_rsp_valid;
  assign accept       = io_req_valid && io_req_ready;
  assign wr_fire      = accept && io_req_write && dec.hit;
  assign wdata16      = io_req_byte ? {2{io_req_wdata[7:0]}} : io_req_wdata;
  assign wbe          = io_req_byte ? (dec.hi_byte ? 2'b10 : 2'b01) : 2'b11;

  pmev_evt_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_set    (evt_vec),
    .tmr_tick   (tmr_tick),
    .wdata      (wdata16),
    .wbe        (wbe),
    .wr_sts     (wr_fire && dec.sel == SEL_STS),
    .wr_en      (wr_fire && dec.sel == SEL_EN),
    .wr_ctl     (wr_fire && dec.sel == SEL_CTL),
    .cmd_valid  (apm_cmd_valid),
    .cmd_data   (apm_cmd_data),
    .misc_we    (cfg_misc_we),
    .misc_wdata (cfg_misc_wdata),
    .strap      (smi_strap),
    .gpe_req    (gpe_req),
    .sts_q      (sts_q),
    .en_q       (en_q),
    .ctl_q      (ctl_q),
    .misc_q     (cfg_misc_q),
    .sci        (sci_o),
    .armed      (tmr_armed),
    .smi        (smi_o)
  );

  assign tmr32 = 32'(tmr_count);

  always_comb begin
    case (dec.sel)
      SEL_STS: sel_val = sts_q;
      SEL_EN:  sel_val = en_q;
      SEL_CTL: sel_val = ctl_q;
      SEL_TMR: sel_val = tmr32[REG_W-1:0];
      default: sel_val = '0;
    endcase
    if (!dec.hit)
      rd_data = '0;
    else if (io_req_byte)
      rd_data = {24'd0, dec.hi_byte ? sel_val[15:8] : sel_val[7:0]};
    else if (dec.sel == SEL_TMR)
      rd_data = tmr32;
    else
      rd_data = {16'd0, sel_val};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rsp_valid <= 1'b0;
      io_rsp_hit   <= 1'b0;
      io_rsp_data  <= '0;
    end else if (accept && !io_req_write) begin
      io_rsp_valid <= 1'b1;
      io_rsp_hit   <= dec.hit;
      io_rsp_data  <= rd_data;
    end else if (io_rsp_valid && io_rsp_ready) begin
      io_rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    io_rsp_valid && !io_rsp_ready |=>
      io_rsp_valid && $stable(io_rsp_data) && $stable(io_rsp_hit)); // R11

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    io_rsp_valid && !io_rsp_hit |-> io_rsp_data == 32'd0); // R1

  AST_SMI_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |-> $past(apm_cmd_valid)); // R9

endmodule

// File: tb/pmev_regblock_tb.sv
module pmev_regblock_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TMR_W      = 12;
  localparam logic [15:0] B = 16'h5A40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_io_base = 32'h1234_5A7F;
  logic        cfg_io_decode = 1'b1;
  logic        cfg_misc_we = 1'b0;
  logic [31:0] cfg_misc_wdata = '0;
  logic [31:0] cfg_misc_q;
  logic        smi_strap = 1'b0;
  logic        io_req_valid = 1'b0;
  logic        io_req_ready;
  logic        io_req_write = 1'b0;
  logic        io_req_byte = 1'b0;
  logic [15:0] io_req_addr = '0;
  logic [15:0] io_req_wdata = '0;
  logic        io_rsp_valid;
  logic        io_rsp_ready = 1'b1;
  logic        io_rsp_hit;
  logic [31:0] io_rsp_data;
  logic        evt_pwrbtn = 1'b0, evt_rtc = 1'b0, evt_glbl = 1'b0;
  logic        gpe_req = 1'b0;
  logic        apm_cmd_valid = 1'b0;
  logic [7:0]  apm_cmd_data = '0;
  logic        sci_o, smi_o, tmr_armed;

  int checks = 0;
  int failures = 0;
  logic [31:0] rd_val;
  logic        rd_hit;

  pmev_regblock #(.TMR_W(TMR_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_io_base(cfg_io_base), .cfg_io_decode(cfg_io_decode),
    .cfg_misc_we(cfg_misc_we), .cfg_misc_wdata(cfg_misc_wdata), .cfg_misc_q(cfg_misc_q),
    .smi_strap(smi_strap),
    .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
    .io_req_write(io_req_write), .io_req_byte(io_req_byte),
    .io_req_addr(io_req_addr), .io_req_wdata(io_req_wdata),
    .io_rsp_valid(io_rsp_valid), .io_rsp_ready(io_rsp_ready),
    .io_rsp_hit(io_rsp_hit), .io_rsp_data(io_rsp_data),
    .evt_pwrbtn(evt_pwrbtn), .evt_rtc(evt_rtc), .evt_glbl(evt_glbl),
    .gpe_req(gpe_req),
    .apm_cmd_valid(apm_cmd_valid), .apm_cmd_data(apm_cmd_data),
    .sci_o(sci_o), .smi_o(smi_o), .tmr_armed(tmr_armed)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    smi_strap = strap;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [15:0] d, input logic by);
    @(negedge clk);
    io_req_valid = 1'b1; io_req_write = 1'b1; io_req_byte = by;
    io_req_addr = a; io_req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    io_req_valid = 1'b0; io_req_write = 1'b0; io_req_byte = 1'b0;
  endtask

  task automatic io_rd(input logic [15:0] a, input logic by);
    @(negedge clk);
    io_req_valid = 1'b1; io_req_write = 1'b0; io_req_byte = by; io_req_addr = a;
    @(posedge clk);
    @(negedge clk);
    io_req_valid = 1'b0; io_req_byte = 1'b0;
    rd_val = io_rsp_data;
    rd_hit = io_rsp_hit;
    chk("R11 rsp valid after read", 32'(io_rsp_valid), 32'd1);
  endtask

  task automatic pulse_evt(input logic pb, input logic rtc, input logic gl);
    @(negedge clk);
    evt_pwrbtn = pb; evt_rtc = rtc; evt_glbl = gl;
    @(negedge clk);
    evt_pwrbtn = 1'b0; evt_rtc = 1'b0; evt_glbl = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
    chk("R10 misc after reset strap=0", cfg_misc_q, 32'd0);
    chk("R5 sci idle after reset", 32'(sci_o), 32'd0);
    chk("R7 armed after reset", 32'(tmr_armed), 32'd0);
    chk("R11 req ready after reset", 32'(io_req_ready), 32'd1);
    io_rd(B + 16'h02, 1'b0); chk("R10 enable reset", rd_val, 32'd0);
    io_rd(B + 16'h04, 1'b0); chk("R10 control reset", rd_val, 32'd0);
  endtask

  task automatic t_register_map();
    io_wr(B + 16'h02, 16'hA5C2, 1'b0);
    io_rd(B + 16'h02, 1'b0); chk("R2 enable word", rd_val, 32'h0000_A5C2);
    io_wr(B + 16'h04, 16'h1234, 1'b0);
    io_rd(B + 16'h04, 1'b0); chk("R2 control word", rd_val, 32'h0000_1234);
    io_wr(B + 16'h06, 16'hFFFF, 1'b0);
    io_rd(B + 16'h06, 1'b0); chk("R2 unmapped 0x06 reads zero", rd_val, 32'd0);
    chk("R2 unmapped still hits", 32'(rd_hit), 32'd1);
    io_rd(B + 16'h0C, 1'b0); chk("R2 unmapped 0x0C reads zero", rd_val, 32'd0);
    io_rd(B + 16'h02, 1'b0); chk("R2 enable unchanged by other offset", rd_val, 32'h0000_A5C2);
  endtask

  task automatic t_window();
    logic [31:0] t1;
    io_rd(B + 16'h40, 1'b0);
    chk("R1 above window miss", 32'(rd_hit), 32'd0);
    chk("R1 miss data zero", rd_val, 32'd0);
    io_wr(16'h5A02, 16'h0000, 1'b0);
    io_rd(B + 16'h02, 1'b0); chk("R1 miss write ignored", rd_val, 32'h0000_A5C2);
    cfg_io_decode = 1'b0;
    io_rd(B + 16'h02, 1'b0);
    chk("R1 decode disabled miss", 32'(rd_hit), 32'd0);
    chk("R1 decode disabled data", rd_val, 32'd0);
    cfg_io_decode = 1'b1;
    io_rd(B + 16'h08, 1'b0);
    t1 = rd_val;
    io_rd(B + 16'h08, 1'b0);
    chk("R6 timer advances 2 between reads", 32'((rd_val - t1) & 32'hFFF), 32'd2);
    chk("R2 timer zero-extended", rd_val & 32'hFFFF_F000, 32'd0);
  endtask

  task automatic t_bytes();
    io_wr(B + 16'h03, 16'hEE77, 1'b1);
    io_rd(B + 16'h02, 1'b0); chk("R3 high byte write", rd_val, 32'h0000_77C2);
    io_wr(B + 16'h02, 16'h0011, 1'b1);
    io_rd(B + 16'h02, 1'b0); chk("R3 low byte write", rd_val, 32'h0000_7711);
    io_rd(B + 16'h03, 1'b1); chk("R3 high byte read", rd_val, 32'h0000_0077);
    io_rd(B + 16'h02, 1'b1); chk("R3 low byte read", rd_val, 32'h0000_0011);
  endtask

  task automatic t_status_w1c();
    io_wr(B + 16'h02, 16'h0000, 1'b0);
    io_wr(B + 16'h00, 16'hFFFF, 1'b0);
    pulse_evt(1'b1, 1'b1, 1'b1);
    io_rd(B + 16'h00, 1'b0);
    chk("R4 events set bits 5,8,10", rd_val & 32'hFFFE, 32'h0000_0520);
    io_wr(B + 16'h00, 16'h0000, 1'b0);
    io_rd(B + 16'h00, 1'b0);
    chk("R4 write zero keeps status", rd_val & 32'hFFFE, 32'h0000_0520);
    io_wr(B + 16'h01, 16'h0001, 1'b1);
    io_rd(B + 16'h00, 1'b0);
    chk("R4 byte W1C clears bit 8 only", rd_val & 32'hFFFE, 32'h0000_0420);
    @(negedge clk);
    evt_pwrbtn = 1'b1;
    io_req_valid = 1'b1; io_req_write = 1'b1; io_req_byte = 1'b0;
    io_req_addr = B; io_req_wdata = 16'h0100;
    @(posedge clk);
    @(negedge clk);
    evt_pwrbtn = 1'b0; io_req_valid = 1'b0; io_req_write = 1'b0;
    io_rd(B + 16'h00, 1'b0);
    chk("R4 event wins over clear", rd_val & 32'h0100, 32'h0000_0100);
    io_wr(B + 16'h00, 16'hFFFF, 1'b0);
    io_rd(B + 16'h00, 1'b0);
    chk("R4 unimplemented/cleared bits zero", rd_val & 32'hFFFE, 32'd0);
  endtask

  task automatic t_sci();
    io_wr(B + 16'h02, 16'h0000, 1'b0);
    io_wr(B + 16'h00, 16'hFFFF, 1'b0);
    pulse_evt(1'b1, 1'b0, 1'b0);
    chk("R5 sci low while disabled", 32'(sci_o), 32'd0);
    io_wr(B + 16'h02, 16'h0100, 1'b0);
    chk("R5 sci follows enable write", 32'(sci_o), 32'd1);
    io_wr(B + 16'h00, 16'h0100, 1'b0);
    chk("R5 sci drops after W1C", 32'(sci_o), 32'd0);
    io_wr(B + 16'h02, 16'h8000, 1'b0);
    pulse_evt(1'b1, 1'b1, 1'b1);
    chk("R5 non-source enable bit gives no sci", 32'(sci_o), 32'd0);
    @(negedge clk); gpe_req = 1'b1; #1;
    chk("R5 gpe request raises sci", 32'(sci_o), 32'd1);
    @(negedge clk); gpe_req = 1'b0; #1;
    chk("R5 gpe request released", 32'(sci_o), 32'd0);
    io_wr(B + 16'h02, 16'h0020, 1'b0);
    chk("R5 global lock source", 32'(sci_o), 32'd1);
    io_wr(B + 16'h02, 16'h0400, 1'b0);
    chk("R5 rtc source", 32'(sci_o), 32'd1);
    io_wr(B + 16'h00, 16'hFFFF, 1'b0);
    chk("R5 all cleared", 32'(sci_o), 32'd0);
  endtask

  task automatic t_timer();
    int waited;
    io_wr(B + 16'h02, 16'h0001, 1'b0);
    io_wr(B + 16'h00, 16'h0001, 1'b0);
    chk("R7 armed with enable and clear status", 32'(tmr_armed), 32'd1);
    waited = 0;
    while (!sci_o && waited < (1 << TMR_W)) begin
      @(negedge clk);
      waited++;
    end
    chk("R6 msb change sets timer status", 32'(sci_o), 32'd1);
    chk("R7 disarmed once status set", 32'(tmr_armed), 32'd0);
    io_rd(B + 16'h00, 1'b0);
    chk("R6 timer status bit 0", rd_val & 32'h1, 32'h1);
    io_wr(B + 16'h02, 16'h0000, 1'b0);
    chk("R7 disarmed with enable clear", 32'(tmr_armed), 32'd0);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk);
    apm_cmd_valid = 1'b1; apm_cmd_data = c;
    @(posedge clk);
    @(negedge clk);
    apm_cmd_valid = 1'b0;
  endtask

  task automatic t_cmd_smi();
    io_wr(B + 16'h04, 16'h1234, 1'b0);
    send_cmd(8'hF1);
    chk("R9 no smi when not allowed", 32'(smi_o), 32'd0);
    io_rd(B + 16'h04, 1'b0); chk("R8 F1 sets sci enable", rd_val, 32'h0000_1235);
    send_cmd(8'h55);
    io_rd(B + 16'h04, 1'b0); chk("R8 other command no effect", rd_val, 32'h0000_1235);
    send_cmd(8'hF0);
    io_rd(B + 16'h04, 1'b0); chk("R8 F0 clears sci enable", rd_val, 32'h0000_1234);
    @(negedge clk);
    cfg_misc_we = 1'b1; cfg_misc_wdata = 32'h0200_00A5;
    @(negedge clk);
    cfg_misc_we = 1'b0;
    chk("R10 misc load", cfg_misc_q, 32'h0200_00A5);
    send_cmd(8'h55);
    chk("R9 smi pulse after command", 32'(smi_o), 32'd1);
    @(negedge clk);
    chk("R9 smi one cycle", 32'(smi_o), 32'd0);
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    io_wr(B + 16'h02, 16'h3C3C, 1'b0);
    io_rsp_ready = 1'b0;
    io_rd(B + 16'h02, 1'b0);
    held = io_rsp_data;
    chk("R11 read data", held, 32'h0000_3C3C);
    chk("R11 ready low while pending", 32'(io_req_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk("R11 rsp held valid", 32'(io_rsp_valid), 32'd1);
    chk("R11 rsp data stable", io_rsp_data, held);
    io_rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 rsp consumed", 32'(io_rsp_valid), 32'd0);
    chk("R11 ready restored", 32'(io_req_ready), 32'd1);
  endtask

  task automatic t_strap();
    do_reset(1'b1);
    chk("R10 strap presets smi-allow", cfg_misc_q, 32'h0200_0000);
    io_rd(B + 16'h04, 1'b0); chk("R10 control cleared", rd_val, 32'd0);
    send_cmd(8'h00);
    chk("R9 smi after strap", 32'(smi_o), 32'd1);
    do_reset(1'b0);
    chk("R10 no strap misc zero", cfg_misc_q, 32'd0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=200000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    t_reset_state();
    t_register_map();
    t_window();
    t_bytes();
    t_status_w1c();
    t_sci();
    t_timer();
    t_cmd_smi();
    t_backpressure();
    t_strap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule